// File: doc/BRIEF.md
# Per-CPU Interrupt Delivery Unit

This block holds the interrupt state that a multi-processor interrupt controller keeps for one destination CPU. It records which sources have been raised toward the CPU and which ones the CPU is servicing. It also holds a current task priority that filters incoming requests. The block drives one level-sensitive interrupt line to the CPU.

An upstream routing stage sends it delivery requests. Each request carries a source index and a 4-bit priority. The CPU claims the best raised source with an acknowledge strobe, which returns that source's vector. The CPU retires the best source in service with an end-of-interrupt strobe.

The priority and vector of every source arrive as flat tables on a lookup port. The block uses them to rank the raised set and the in-service set, and each ranking is a combinational priority encoder. When two sources have equal priority, the lower source index wins. The block reports each accepted request as a one-hot activity pulse, so the source stage can mark that source active.

Top module: `cpu_irq_dest`

## Requirements
- R1: After reset: `irq_o` is 0, `raised_o` and `servicing_o` are all zero, `ctp_o` is 4'hF, and the spurious vector is 8'hFF.
- R2: A request with `req_prio_i` less than or equal to `ctp_o` is dropped. `act_set_o` stays zero and no state changes. A request with priority 0 is therefore always dropped.
- R3: A request whose source bit is already set in `raised_o` is a miss. It is dropped, and `act_set_o` stays zero in that cycle.
- R4: An accepted request drives `act_set_o` one-hot at bit `req_src_i` in the same cycle. It sets that bit of `raised_o` from the next cycle.
- R5: An accepted request sets `irq_o` in the next cycle only under two conditions. First, the raised set was empty, or the request priority is at least the highest raised priority. Second, the in-service set was empty, or the request priority is at least the highest in-service priority. Otherwise `irq_o` keeps its value. `irq_o` is never 1 while `raised_o` is zero.
- R6: While `iack_i` is high, `iack_vec_o` gives the vector of the highest-priority raised source, with ties going to the lowest index. In the next cycle `irq_o` is 0 (unless R12 applies), and that source's bit has moved from `raised_o` to `servicing_o`.
- R7: An acknowledge with nothing raised returns the spurious vector. It leaves `raised_o` and `servicing_o` unchanged and clears `irq_o`.
- R8: End-of-interrupt clears the bit of the highest-priority source in service, with ties going to the lowest index.
- R9: After end-of-interrupt, `irq_o` is set when both of these hold: the raised set is non-empty, and either nothing remains in service or the best raised priority is strictly greater than the best remaining in-service priority. Otherwise `irq_o` keeps its value.
- R10: Writing with `ctp_we_i` loads `ctp_o`. Writing with `spv_we_i` loads the spurious vector.
- R11: If `iack_i` and `eoi_i` are high in the same cycle, the acknowledge takes effect and the end-of-interrupt is ignored.
- R12: A request in the same cycle as an acknowledge is judged against the state from before that cycle. Its miss check and its priority comparisons both use that state. If it sets `irq_o`, that overrides the clear from the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_prio_i | input | NUM_SRC*PRIO_W | Priority of each source, source i at bits [i*PRIO_W +: PRIO_W] |
| src_vec_i | input | NUM_SRC*VEC_W | Vector of each source, source i at bits [i*VEC_W +: VEC_W] |
| req_valid_i | input | 1 | Delivery request strobe |
| req_src_i | input | SRC_W | Source index of the request |
| req_prio_i | input | PRIO_W | Priority of the request |
| act_set_o | output | NUM_SRC | One-hot pulse that marks an accepted source active |
| ctp_we_i | input | 1 | Task priority write strobe |
| ctp_wdata_i | input | PRIO_W | Task priority write data |
| ctp_o | output | PRIO_W | Current task priority |
| spv_we_i | input | 1 | Spurious vector write strobe |
| spv_wdata_i | input | VEC_W | Spurious vector write data |
| iack_i | input | 1 | Acknowledge read strobe |
| iack_vec_o | output | VEC_W | Vector returned by the acknowledge (valid while iack_i is high) |
| eoi_i | input | 1 | End-of-interrupt strobe |
| irq_o | output | 1 | Level interrupt to the CPU |
| raised_o | output | NUM_SRC | Raised source set |
| servicing_o | output | NUM_SRC | In-service source set |

## Verification
A delivery request can land in the same cycle as an acknowledge, and an acknowledge can land in the same cycle as an end-of-interrupt. The bench drives both overlaps in one clock.

In the first overlap, the bench checks three things. The request must be judged against the pre-cycle raised set: a request for a newly raised source is accepted, while a request for a source that is still raised is a miss. The returned vector must still belong to the old top source. The interrupt line must stay high only when the request itself qualifies.

In the second overlap, the bench checks that the acknowledge moves its source into service while the in-service bit that end-of-interrupt would have cleared stays set.

// File: rtl/cid_pkg.sv
package cid_pkg;
  localparam int unsigned CID_PRIO_W  = 4;
  localparam int unsigned CID_VEC_W   = 8;
  localparam int unsigned CID_NUM_SRC = 16;
endpackage

// File: rtl/cid_prio_enc.sv
module cid_prio_enc #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        bits_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      any_o,
  output logic [SRC_W-1:0]          idx_o,
  output logic [PRIO_W-1:0]         prio_o
);
  // Scan from high index down with >=, so the lowest index wins ties.
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    prio_o = '0;
    for (int i = NUM_SRC-1; i >= 0; i--) begin
      if (bits_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] >= prio_o)) begin
        any_o  = 1'b1;
        idx_o  = SRC_W'(i);
        prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/cid_cfg_regs.sv
module cid_cfg_regs #(
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctp_we_i,
  input  logic [PRIO_W-1:0] ctp_wdata_i,
  input  logic              spv_we_i,
  input  logic [VEC_W-1:0]  spv_wdata_i,
  output logic [PRIO_W-1:0] ctp_o,
  output logic [VEC_W-1:0]  spv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctp_o <= '1;
      spv_o <= '1;
    end else begin
      if (ctp_we_i) ctp_o <= ctp_wdata_i;
      if (spv_we_i) spv_o <= spv_wdata_i;
    end
  end
endmodule

// File: rtl/cpu_irq_dest.sv
module cpu_irq_dest import cid_pkg::*; #(
  parameter int unsigned NUM_SRC = CID_NUM_SRC,
  parameter int unsigned PRIO_W  = CID_PRIO_W,
  parameter int unsigned VEC_W   = CID_VEC_W,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
  input  logic [NUM_SRC*VEC_W-1:0]  src_vec_i,
  input  logic                      req_valid_i,
  input  logic [SRC_W-1:0]          req_src_i,
  input  logic [PRIO_W-1:0]         req_prio_i,
  output logic [NUM_SRC-1:0]        act_set_o,
  input  logic                      ctp_we_i,
  input  logic [PRIO_W-1:0]         ctp_wdata_i,
  output logic [PRIO_W-1:0]         ctp_o,
  input  logic                      spv_we_i,
  input  logic [VEC_W-1:0]          spv_wdata_i,
  input  logic                      iack_i,
  output logic [VEC_W-1:0]          iack_vec_o,
  input  logic                      eoi_i,
  output logic                      irq_o,
  output logic [NUM_SRC-1:0]        raised_o,
  output logic [NUM_SRC-1:0]        servicing_o
);
  logic [NUM_SRC-1:0] raised_q, raised_d, serv_q, serv_d, serv_post;
  logic               irq_q, irq_d;
  logic [VEC_W-1:0]   spv;

  logic              r_any, s_any, p_any;
  logic [SRC_W-1:0]  r_idx, s_idx, p_idx;
  logic [PRIO_W-1:0] r_prio, s_prio, p_prio;

  logic req_hit, req_fire, eoi_go, eoi_fire;

  cid_cfg_regs #(.PRIO_W(PRIO_W), .VEC_W(VEC_W)) i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctp_we_i    (ctp_we_i),
    .ctp_wdata_i (ctp_wdata_i),
    .spv_we_i    (spv_we_i),
    .spv_wdata_i (spv_wdata_i),
    .ctp_o       (ctp_o),
    .spv_o       (spv)
  );

  // Best raised source
  cid_prio_enc #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_enc_raised (
    .bits_i (raised_q), .prio_i (src_prio_i),
    .any_o  (r_any), .idx_o (r_idx), .prio_o (r_prio)
  );

  // Best source in service
  cid_prio_enc #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_enc_serv (
    .bits_i (serv_q), .prio_i (src_prio_i),
    .any_o  (s_any), .idx_o (s_idx), .prio_o (s_prio)
  );

  // Best source left in service after end-of-interrupt
  always_comb begin
    serv_post = serv_q;
    if (s_any) serv_post[s_idx] = 1'b0;
  end

  cid_prio_enc #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_enc_post (
    .bits_i (serv_post), .prio_i (src_prio_i),
    .any_o  (p_any), .idx_o (p_idx), .prio_o (p_prio)
  );

  assign req_hit  = req_valid_i && (req_prio_i > ctp_o) && !raised_q[req_src_i];
  assign req_fire = req_hit && (!r_any || req_prio_i >= r_prio)
                            && (!s_any || req_prio_i >= s_prio);
  assign eoi_go   = eoi_i && !iack_i;
  assign eoi_fire = eoi_go && r_any && (!p_any || r_prio > p_prio);

  always_comb begin
    act_set_o = '0;
    if (req_hit) act_set_o[req_src_i] = 1'b1;
  end

  assign iack_vec_o = r_any ? src_vec_i[r_idx*VEC_W +: VEC_W] : spv;

  always_comb begin
    raised_d = raised_q;
    serv_d   = eoi_go ? serv_post : serv_q;
    irq_d    = irq_q;
    if (iack_i) begin
      irq_d = 1'b0;
      if (r_any) begin
        raised_d[r_idx] = 1'b0;
        serv_d[r_idx]   = 1'b1;
      end
    end
    if (req_hit) raised_d[req_src_i] = 1'b1;
    if (req_fire || eoi_fire) irq_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raised_q <= '0;
      serv_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      raised_q <= raised_d;
      serv_q   <= serv_d;
      irq_q    <= irq_d;
    end
  end

  assign irq_o       = irq_q;
  assign raised_o    = raised_q;
  assign servicing_o = serv_q;
endmodule

// File: rtl/cpu_irq_dest_chk.sv
module cpu_irq_dest_chk #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [SRC_W-1:0]   req_src_i,
  input logic [PRIO_W-1:0]  req_prio_i,
  input logic [NUM_SRC-1:0] act_set_o,
  input logic [PRIO_W-1:0]  ctp_o,
  input logic               iack_i,
  input logic               eoi_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] raised_o,
  input logic [NUM_SRC-1:0] servicing_o
);
  assert_low_prio_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_prio_i <= ctp_o) |-> act_set_o == '0);

  assert_miss_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && raised_o[req_src_i]) |-> act_set_o == '0);

  assert_act_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_set_o));

  assert_act_raises_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_set_o != '0) |=> ((raised_o & $past(act_set_o)) != '0));

  assert_irq_has_raised_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> raised_o != '0);

  assert_iack_clears_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && !req_valid_i) |=> !irq_o);

  assert_iack_pops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && !req_valid_i && raised_o != '0)
      |=> $countones(raised_o) == $countones($past(raised_o)) - 1);

  assert_eoi_pops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !iack_i && servicing_o != '0)
      |=> $countones(servicing_o) == $countones($past(servicing_o)) - 1);

  assert_eoi_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && iack_i) |=> (servicing_o & $past(servicing_o)) == $past(servicing_o));
endmodule

bind cpu_irq_dest cpu_irq_dest_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_src_i   (req_src_i),
  .req_prio_i  (req_prio_i),
  .act_set_o   (act_set_o),
  .ctp_o       (ctp_o),
  .iack_i      (iack_i),
  .eoi_i       (eoi_i),
  .irq_o       (irq_o),
  .raised_o    (raised_o),
  .servicing_o (servicing_o)
);

// File: tb/test_cpu_irq_dest.sv
module test_cpu_irq_dest;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC = 16;
  localparam int PRIO_W  = 4;
  localparam int VEC_W   = 8;
  localparam int SRC_W   = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NUM_SRC*PRIO_W-1:0] src_prio;
  logic [NUM_SRC*VEC_W-1:0]  src_vec;
  logic req_valid = 1'b0;
  logic [SRC_W-1:0] req_src = '0;
  logic [PRIO_W-1:0] req_prio = '0;
  logic [NUM_SRC-1:0] act_set;
  logic ctp_we = 1'b0;
  logic [PRIO_W-1:0] ctp_wdata = '0;
  logic [PRIO_W-1:0] ctp;
  logic spv_we = 1'b0;
  logic [VEC_W-1:0] spv_wdata = '0;
  logic iack = 1'b0;
  logic [VEC_W-1:0] iack_vec;
  logic eoi = 1'b0;
  logic irq;
  logic [NUM_SRC-1:0] raised, servicing;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_irq_dest #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) i_cpu_irq_dest (
    .clk_i (clk), .rst_ni (rst_ni),
    .src_prio_i (src_prio), .src_vec_i (src_vec),
    .req_valid_i (req_valid), .req_src_i (req_src), .req_prio_i (req_prio),
    .act_set_o (act_set),
    .ctp_we_i (ctp_we), .ctp_wdata_i (ctp_wdata), .ctp_o (ctp),
    .spv_we_i (spv_we), .spv_wdata_i (spv_wdata),
    .iack_i (iack), .iack_vec_o (iack_vec), .eoi_i (eoi),
    .irq_o (irq), .raised_o (raised), .servicing_o (servicing)
  );

  function automatic logic [PRIO_W-1:0] prio_of(int s);
    case (s)
      0: return 4'd2;
      1: return 4'd7;
      2: return 4'd7;
      3: return 4'd6;
      4: return 4'd9;
      5: return 4'd3;
      default: return 4'd1;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < NUM_SRC; i++) begin
      src_prio[i*PRIO_W +: PRIO_W] = prio_of(i);
      src_vec[i*VEC_W +: VEC_W]    = VEC_W'(8'h40 + i);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_valid = 0; iack = 0; eoi = 0; ctp_we = 0; spv_we = 0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_ctp(input int v);
    ctp_we = 1; ctp_wdata = PRIO_W'(v);
    @(negedge clk);
    ctp_we = 0;
  endtask

  // Deliver a request; returns the same-cycle activity pulse.
  task automatic deliver(input int s, output int act);
    req_valid = 1; req_src = SRC_W'(s); req_prio = prio_of(s);
    #1 act = int'(act_set);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic deliver_p(input int s, input int p, output int act);
    req_valid = 1; req_src = SRC_W'(s); req_prio = PRIO_W'(p);
    #1 act = int'(act_set);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic ack(output int vec);
    iack = 1;
    #1 vec = int'(iack_vec);
    @(negedge clk);
    iack = 0;
  endtask

  task automatic end_irq();
    eoi = 1;
    @(negedge clk);
    eoi = 0;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    chk_eq("R1 irq", int'(irq), 0);
    chk_eq("R1 raised", int'(raised), 0);
    chk_eq("R1 servicing", int'(servicing), 0);
    chk_eq("R1 ctp", int'(ctp), 15);
    ack(v);
    chk_eq("R1 R7 spurious reset", v, 8'hFF);
    chk_eq("R7 raised unchanged", int'(raised), 0);
    chk_eq("R7 servicing unchanged", int'(servicing), 0);
  endtask

  task automatic t_ctp();
    int a;
    do_reset();
    deliver(3, a);
    chk_eq("R2 blocked at ctp F act", a, 0);
    chk_eq("R2 blocked at ctp F raised", int'(raised), 0);
    set_ctp(5);
    chk_eq("R10 ctp write", int'(ctp), 5);
    deliver_p(3, 5, a);
    chk_eq("R2 equal prio act", a, 0);
    chk_eq("R2 equal prio raised", int'(raised), 0);
    chk_eq("R2 equal prio irq", int'(irq), 0);
    set_ctp(0);
    deliver_p(5, 0, a);
    chk_eq("R2 zero prio act", a, 0);
    chk_eq("R2 zero prio raised", int'(raised), 0);
  endtask

  task automatic t_basic();
    int a, v;
    do_reset();
    set_ctp(0);
    deliver(3, a);
    chk_eq("R4 act pulse", a, 16'h0008);
    chk_eq("R4 raised", int'(raised), 16'h0008);
    chk_eq("R5 irq set", int'(irq), 1);
    deliver(3, a);
    chk_eq("R3 miss act", a, 0);
    chk_eq("R3 miss raised", int'(raised), 16'h0008);
    ack(v);
    chk_eq("R6 vector", v, 8'h43);
    chk_eq("R6 irq cleared", int'(irq), 0);
    chk_eq("R6 raised", int'(raised), 0);
    chk_eq("R6 servicing", int'(servicing), 16'h0008);
    end_irq();
    chk_eq("R8 servicing cleared", int'(servicing), 0);
    chk_eq("R9 no raised no irq", int'(irq), 0);
  endtask

  task automatic t_hidden();
    int a, v;
    do_reset();
    set_ctp(0);
    deliver(4, a);
    ack(v);
    chk_eq("R6 vector src4", v, 8'h44);
    deliver(3, a);
    chk_eq("R4 accepted under service", a, 16'h0008);
    chk_eq("R5 hidden by service", int'(irq), 0);
    deliver(1, a);
    chk_eq("R5 hidden by service 2", int'(irq), 0);
    chk_eq("R5 raised pair", int'(raised), 16'h000A);
    end_irq();
    chk_eq("R8 src4 retired", int'(servicing), 0);
    chk_eq("R9 reassert after eoi", int'(irq), 1);
    ack(v);
    chk_eq("R6 best raised", v, 8'h41);
    chk_eq("R6 servicing src1", int'(servicing), 16'h0002);
    chk_eq("R6 raised src3", int'(raised), 16'h0008);
    chk_eq("R6 irq low", int'(irq), 0);
    end_irq();
    chk_eq("R9 reassert empty service", int'(irq), 1);
  endtask

  task automatic t_tie();
    int a, v;
    do_reset();
    set_ctp(0);
    deliver(2, a);
    deliver(1, a);
    chk_eq("R5 equal prio keeps irq", int'(irq), 1);
    ack(v);
    chk_eq("R6 tie lowest index", v, 8'h41);
    ack(v);
    chk_eq("R6 tie second", v, 8'h42);
    chk_eq("R6 both serviced", int'(servicing), 16'h0006);
    end_irq();
    chk_eq("R8 tie clears lowest", int'(servicing), 16'h0004);
    end_irq();
    chk_eq("R8 cleared all", int'(servicing), 0);
    // strict comparison on eoi
    do_reset();
    set_ctp(0);
    deliver(2, a);
    ack(v);
    deliver(4, a);
    chk_eq("R5 above service", int'(irq), 1);
    ack(v);
    deliver(1, a);
    chk_eq("R5 below service", int'(irq), 0);
    end_irq();
    chk_eq("R8 clears src4", int'(servicing), 16'h0004);
    chk_eq("R9 equal prio no reassert", int'(irq), 0);
    end_irq();
    chk_eq("R9 reassert after last", int'(irq), 1);
  endtask

  task automatic t_collide();
    int a, v;
    do_reset();
    set_ctp(0);
    deliver(3, a);
    req_valid = 1; req_src = 4'd4; req_prio = prio_of(4); iack = 1;
    #1 a = int'(act_set); v = int'(iack_vec);
    @(negedge clk);
    req_valid = 0; iack = 0;
    chk_eq("R12 accept during ack", a, 16'h0010);
    chk_eq("R12 ack vector", v, 8'h43);
    chk_eq("R12 irq kept", int'(irq), 1);
    chk_eq("R12 raised", int'(raised), 16'h0010);
    chk_eq("R12 servicing", int'(servicing), 16'h0008);
    req_valid = 1; req_src = 4'd4; req_prio = prio_of(4); iack = 1;
    #1 a = int'(act_set); v = int'(iack_vec);
    @(negedge clk);
    req_valid = 0; iack = 0;
    chk_eq("R12 miss uses old state", a, 0);
    chk_eq("R12 ack vector 2", v, 8'h44);
    chk_eq("R12 irq cleared", int'(irq), 0);
    chk_eq("R12 raised empty", int'(raised), 0);
    chk_eq("R12 servicing both", int'(servicing), 16'h0018);
  endtask

  task automatic t_ack_eoi();
    int a, v;
    do_reset();
    set_ctp(0);
    deliver(3, a);
    ack(v);
    deliver(1, a);
    chk_eq("R5 irq over service", int'(irq), 1);
    iack = 1; eoi = 1;
    #1 v = int'(iack_vec);
    @(negedge clk);
    iack = 0; eoi = 0;
    chk_eq("R11 ack vector", v, 8'h41);
    chk_eq("R11 eoi ignored", int'(servicing), 16'h000A);
    chk_eq("R11 irq cleared", int'(irq), 0);
  endtask

  task automatic t_spv();
    int v;
    do_reset();
    spv_we = 1; spv_wdata = 8'h2C;
    @(negedge clk);
    spv_we = 0;
    ack(v);
    chk_eq("R10 R7 spurious write", v, 8'h2C);
    chk_eq("R7 irq low", int'(irq), 0);
  endtask

  initial begin
    t_reset();
    t_ctp();
    t_basic();
    t_hidden();
    t_tie();
    t_collide();
    t_ack_eoi();
    t_spv();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule